// File: doc/BRIEF.md
# I2C Master Waveform Timing Generator

This block turns single bus commands into the SCL and SDA line waveforms of an I2C master. A command is one of: begin a transfer (a start condition, or a repeated start while the bus is already held), shift out one data bit, or end the transfer with a stop condition. Every interval on the bus comes from one programmed SCL period, counted in system clocks, plus or minus a few clock cycles. There are no separate setup or hold settings. The same logic therefore serves the standard speed class and the faster class; only the period value changes.

Both lines are driven as open-drain enables. A 1 on an output pulls its line low, and a 0 releases it. A surrounding controller issues one command, waits for the one-cycle completion pulse, and then issues the next command. Byte framing, acknowledge handling, arbitration, slave clock stretching and analog edge compensation belong to the surrounding logic.

In the text below, P is the period value captured when a command is accepted and H = P/2. "Prompt" means the next command is presented so that it is accepted on the first clock edge after the completion pulse.

Top module: `i2cw_master_wave`

## Requirements
- R1: During reset and right after it, both pull enables are 0 (lines released) and the completion pulse is low.
- R2: Command code 00 (start), accepted while the bus is free, pulls SDA on the edge of acceptance and pulls SCL H-1 cycles later. The completion pulse is high in the cycle in which SCL becomes pulled.
- R3: Command code 01 (write bit) keeps SCL pulled for H cycles after its falling edge when issued promptly, releases SCL for H cycles, then pulls SCL again with the completion pulse in that same cycle.
- R4: After any SCL fall, SDA holds its value for exactly 3 cycles (prompt case) before it may change, and the SDA value is then set up H-3 cycles before SCL is released.
- R5: With data value 1 the SDA line is released while SCL is high, and with value 0 it is pulled. SDA never changes while SCL is released except to form a start or a stop, and the two pull enables never change in the same cycle.
- R6: Command code 10 (stop) pulls SDA during the low phase, releases SCL, and releases SDA H+2 cycles after SCL was released. The completion pulse follows H-2 cycles after the SDA release, with both lines released.
- R7: Command code 00 accepted while the bus is held gives a repeated start: SDA is released during the low phase, SCL is released, SDA is pulled P cycles after SCL was released, and SCL is pulled H-1 cycles after that.
- R8: A start issued promptly after a stop's completion pulse pulls SDA exactly H-1 cycles after the stop released SDA, where H is taken from the stop's period.
- R9: The completion pulse lasts one cycle, and exactly one pulse occurs for each accepted command.
- R10: Commands presented while a command is in progress are ignored. While the bus is free, codes 01, 10 and 11 are ignored. While the bus is held, code 11 is ignored. An ignored command changes neither line and produces no pulse.
- R11: The period is captured at acceptance and must be even and at least 16. At a 50 MHz clock, P=500 yields at least 4000 ns high, 4700 ns low and 4700 ns bus free, and P=132 yields at least 600 ns high and 1300 ns low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 2 | Command code: 00 start, 01 write bit, 10 stop, 11 none |
| cmd_bit_i | input | 1 | Data value for a write-bit command |
| period_i | input | PW | SCL period in system clocks, even, at least 16 |
| scl_pull_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| done_o | output | 1 | One-cycle pulse when a command completes |

## Verification
The bench builds the block with its default parameters: a 12-bit period and a 3-cycle data hold. It drives periods from the minimum value of 16 up to 78 at random, and also uses 132 and 500. The period of 16 leaves only a 5-cycle setup phase and a 7-cycle start hold, so it tests the shortest phases and the windows in which injected commands must be ignored. The periods 132 and 500 take the measured high, low and bus-free times to the nanosecond targets of the two speed classes. Held reserved codes and idle-time commands delay the next accepted command, which makes the late-command path of the hold logic take effect.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    // Command codes seen at the command port.
    typedef enum logic [1:0] {
        OP_START = 2'b00,
        OP_WRITE = 2'b01,
        OP_STOP  = 2'b10,
        OP_NONE  = 2'b11
    } op_e;

    // Sequencer phases.
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,   // bus free, both lines released
        S_OWN   = 3'd1,   // bus held, SCL pulled, waiting for a command
        S_HOLD  = 3'd2,   // SCL pulled, SDA still holding the previous value
        S_LOW   = 3'd3,   // SCL pulled, SDA at its new value
        S_HIGH  = 3'd4,   // SCL released
        S_SHOLD = 3'd5,   // SDA pulled with SCL released (start hold)
        S_FREE  = 3'd6    // bus-free gap after a stop
    } st_e;

endpackage

// File: rtl/i2cw_span.sv
// Derives every phase length from the active period. Outputs are
// counter load values, i.e. phase length minus one.
module i2cw_span #(
    parameter int PW   = 12,
    parameter int HOLD = 3
) (
    input  logic [PW-1:0] per_i,
    output logic [PW-1:0] ld_shold_o,
    output logic [PW-1:0] ld_low_o,
    output logic [PW-1:0] ld_hi_wr_o,
    output logic [PW-1:0] ld_hi_stop_o,
    output logic [PW-1:0] ld_hi_rs_o,
    output logic [PW-1:0] ld_free_o
);
    localparam logic [PW-1:0] ONE       = PW'(1);
    localparam logic [PW-1:0] TWO       = PW'(2);
    localparam logic [PW-1:0] THREE     = PW'(3);
    localparam logic [PW-1:0] LOW_TRIM  = PW'(HOLD + 1);

    logic [PW-1:0] half;

    always_comb begin
        half         = {1'b0, per_i[PW-1:1]};
        ld_shold_o   = half - TWO;        // H-1 cycles
        ld_low_o     = half - LOW_TRIM;   // H-HOLD cycles
        ld_hi_wr_o   = half - ONE;        // H cycles
        ld_hi_stop_o = half + ONE;        // H+2 cycles
        ld_hi_rs_o   = per_i - ONE;       // P cycles
        ld_free_o    = half - THREE;      // H-2 cycles, next start adds one
    end

endmodule

// File: rtl/i2cw_tick.sv
// Loadable down counter shared by all phases.
module i2cw_tick #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/i2cw_seq.sv
// Bus sequencer: accepts commands and walks the line phases.
module i2cw_seq
    import i2cw_pkg::*;
#(
    parameter int PW   = 12,
    parameter int HOLD = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid_i,
    input  op_e           cmd_op_i,
    input  logic          cmd_bit_i,
    input  logic [PW-1:0] period_i,
    input  logic [PW-1:0] ld_shold_i,
    input  logic [PW-1:0] ld_low_i,
    input  logic [PW-1:0] ld_hi_wr_i,
    input  logic [PW-1:0] ld_hi_stop_i,
    input  logic [PW-1:0] ld_hi_rs_i,
    input  logic [PW-1:0] ld_free_i,
    input  logic          tick_zero_i,
    output logic [PW-1:0] per_use_o,
    output logic          tick_load_o,
    output logic [PW-1:0] tick_val_o,
    output logic          scl_pull_o,
    output logic          sda_pull_o,
    output logic          done_o
);
    localparam int            SW        = $clog2(HOLD + 1);
    localparam logic [SW-1:0] SINCE_MAX = SW'(HOLD);
    localparam logic [SW-1:0] SINCE_OK  = SW'(HOLD - 1);
    localparam logic [PW-1:0] HOLD_BASE = PW'(HOLD - 2);

    typedef struct packed {
        st_e           st;
        op_e           op;
        logic          dbit;
        logic [PW-1:0] per;
        logic          scl;
        logic          sda;
        logic          done;
        logic [SW-1:0] since;   // edges since SCL fell, saturating
    } seq_t;

    seq_t d, q;

    function automatic logic sda_goal(op_e op, logic b);
        case (op)
            OP_WRITE: return ~b;
            OP_STOP:  return 1'b1;
            default:  return 1'b0;
        endcase
    endfunction

    assign per_use_o = (q.st == S_IDLE || q.st == S_OWN) ? period_i : q.per;

    always_comb begin
        d           = q;
        d.done      = 1'b0;
        tick_load_o = 1'b0;
        tick_val_o  = ld_low_i;
        if (q.since < SINCE_MAX) begin
            d.since = q.since + 1'b1;
        end
        case (q.st)
            S_IDLE: begin
                if (cmd_valid_i && cmd_op_i == OP_START) begin
                    d.per       = period_i;
                    d.op        = OP_START;
                    d.sda       = 1'b1;
                    d.st        = S_SHOLD;
                    tick_load_o = 1'b1;
                    tick_val_o  = ld_shold_i;
                end
            end
            S_OWN: begin
                if (cmd_valid_i && cmd_op_i != OP_NONE) begin
                    d.per  = period_i;
                    d.op   = cmd_op_i;
                    d.dbit = cmd_bit_i;
                    tick_load_o = 1'b1;
                    if (q.since >= SINCE_OK) begin
                        d.st       = S_LOW;
                        d.sda      = sda_goal(cmd_op_i, cmd_bit_i);
                        tick_val_o = ld_low_i;
                    end else begin
                        d.st       = S_HOLD;
                        tick_val_o = HOLD_BASE - PW'(q.since);
                    end
                end
            end
            S_HOLD: begin
                if (tick_zero_i) begin
                    d.st        = S_LOW;
                    d.sda       = sda_goal(q.op, q.dbit);
                    tick_load_o = 1'b1;
                    tick_val_o  = ld_low_i;
                end
            end
            S_LOW: begin
                if (tick_zero_i) begin
                    d.scl       = 1'b0;
                    d.st        = S_HIGH;
                    tick_load_o = 1'b1;
                    case (q.op)
                        OP_WRITE: tick_val_o = ld_hi_wr_i;
                        OP_STOP:  tick_val_o = ld_hi_stop_i;
                        default:  tick_val_o = ld_hi_rs_i;
                    endcase
                end
            end
            S_HIGH: begin
                if (tick_zero_i) begin
                    case (q.op)
                        OP_WRITE: begin
                            d.scl   = 1'b1;
                            d.done  = 1'b1;
                            d.st    = S_OWN;
                            d.since = '0;
                        end
                        OP_STOP: begin
                            d.sda       = 1'b0;
                            d.st        = S_FREE;
                            tick_load_o = 1'b1;
                            tick_val_o  = ld_free_i;
                        end
                        default: begin
                            d.sda       = 1'b1;
                            d.st        = S_SHOLD;
                            tick_load_o = 1'b1;
                            tick_val_o  = ld_shold_i;
                        end
                    endcase
                end
            end
            S_SHOLD: begin
                if (tick_zero_i) begin
                    d.scl   = 1'b1;
                    d.done  = 1'b1;
                    d.st    = S_OWN;
                    d.since = '0;
                end
            end
            S_FREE: begin
                if (tick_zero_i) begin
                    d.done = 1'b1;
                    d.st   = S_IDLE;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= S_IDLE;
            q.op    <= OP_NONE;
            q.dbit  <= 1'b0;
            q.per   <= '0;
            q.scl   <= 1'b0;
            q.sda   <= 1'b0;
            q.done  <= 1'b0;
            q.since <= SINCE_MAX;
        end else begin
            q <= d;
        end
    end

    assign scl_pull_o = q.scl;
    assign sda_pull_o = q.sda;
    assign done_o     = q.done;

endmodule

// File: rtl/i2cw_master_wave.sv
module i2cw_master_wave
    import i2cw_pkg::*;
#(
    parameter int PW   = 12,
    parameter int HOLD = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid_i,
    input  logic [1:0]    cmd_op_i,
    input  logic          cmd_bit_i,
    input  logic [PW-1:0] period_i,
    output logic          scl_pull_o,
    output logic          sda_pull_o,
    output logic          done_o
);
    logic [PW-1:0] per_use;
    logic [PW-1:0] ld_shold, ld_low, ld_hi_wr, ld_hi_stop, ld_hi_rs, ld_free;
    logic          tick_load, tick_zero;
    logic [PW-1:0] tick_val;

    i2cw_span #(.PW(PW), .HOLD(HOLD)) u_span (
        .per_i        (per_use),
        .ld_shold_o   (ld_shold),
        .ld_low_o     (ld_low),
        .ld_hi_wr_o   (ld_hi_wr),
        .ld_hi_stop_o (ld_hi_stop),
        .ld_hi_rs_o   (ld_hi_rs),
        .ld_free_o    (ld_free)
    );

    i2cw_tick #(.W(PW)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tick_load),
        .val_i  (tick_val),
        .zero_o (tick_zero)
    );

    i2cw_seq #(.PW(PW), .HOLD(HOLD)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid_i  (cmd_valid_i),
        .cmd_op_i     (op_e'(cmd_op_i)),
        .cmd_bit_i    (cmd_bit_i),
        .period_i     (period_i),
        .ld_shold_i   (ld_shold),
        .ld_low_i     (ld_low),
        .ld_hi_wr_i   (ld_hi_wr),
        .ld_hi_stop_i (ld_hi_stop),
        .ld_hi_rs_i   (ld_hi_rs),
        .ld_free_i    (ld_free),
        .tick_zero_i  (tick_zero),
        .per_use_o    (per_use),
        .tick_load_o  (tick_load),
        .tick_val_o   (tick_val),
        .scl_pull_o   (scl_pull_o),
        .sda_pull_o   (sda_pull_o),
        .done_o       (done_o)
    );

endmodule

// File: rtl/i2cw_master_wave_chk.sv
module i2cw_master_wave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_pull,
    input logic sda_pull,
    input logic done
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                    // R9

    AST_SCL_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull) |-> done);                                          // R2

    AST_ONE_LINE_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> $stable(scl_pull));                          // R5

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull) |=> $stable(sda_pull) ##1 $stable(sda_pull));       // R4

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !scl_pull) |-> !sda_pull);                                 // R6

endmodule

bind i2cw_master_wave i2cw_master_wave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_pull (scl_pull_o),
    .sda_pull (sda_pull_o),
    .done     (done_o)
);

// File: tb/i2cw_master_wave_test.sv
`timescale 1ns/1ps
module i2cw_master_wave_test;
    localparam int PW     = 12;
    localparam int HOLD   = 3;
    localparam int CLK_NS = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'b11;
    logic          cmd_bit = 1'b0;
    logic [PW-1:0] period = PW'(16);
    logic          scl_pull, sda_pull, done;

    always #10 clk = ~clk;

    i2cw_master_wave #(.PW(PW), .HOLD(HOLD)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid_i (cmd_valid),
        .cmd_op_i    (cmd_op),
        .cmd_bit_i   (cmd_bit),
        .period_i    (period),
        .scl_pull_o  (scl_pull),
        .sda_pull_o  (sda_pull),
        .done_o      (done)
    );

    int checks = 0, errors = 0, cyc = 0;
    int cur_kind = 0, cur_bit = 0, cur_half = 8, cur_per = 16, stop_half = 8;
    int t_fall = 0, t_rise = 0, t_sda_low = 0, t_sda_hi_fall = 0, t_stop_rise = 0;
    int last_high = 0, last_low = 0, last_free = 0, n_done = 0, n_sent = 0;
    bit rs_pending = 0, owned = 0, have_stop = 0, sda_moved = 0;
    bit free_relax = 0, low_relax = 0, mon_on = 0;
    logic prev_scl = 1'b0, prev_sda = 1'b0, prev_done = 1'b0;

    task automatic check_eq(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_ge(string req, int act, int lim);
        checks++;
        if (act < lim) begin
            errors++;
            $display("FAIL %s: actual %0d expected at least %0d", req, act, lim);
        end
    endtask

    // Line monitor: measures intervals between edges, sampled at negedge.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && mon_on) begin
            if (scl_pull !== prev_scl && sda_pull !== prev_sda)
                check_eq("R5 both lines changed in one cycle", 1, 0);
            if (scl_pull !== prev_scl) begin
                if (scl_pull) begin
                    if (cur_kind == 0) begin
                        check_eq(rs_pending ? "R7 repeated start hold" : "R2 start hold",
                                 cyc - t_sda_hi_fall, cur_half - 1);
                        check_eq("R2 done with SCL fall", int'(done), 1);
                        rs_pending = 0;
                    end else begin
                        last_high = cyc - t_rise;
                        check_eq("R3 SCL high time", last_high, cur_half);
                        check_eq("R3 done with SCL fall", int'(done), 1);
                    end
                    t_fall = cyc;
                    sda_moved = 0;
                end else begin
                    last_low = cyc - t_fall;
                    if (low_relax) check_ge("R10 low after ignored code", last_low, cur_half);
                    else check_eq("R3 SCL low time", last_low, cur_half);
                    low_relax = 0;
                    if (sda_moved) check_eq("R4 data setup", cyc - t_sda_low, cur_half - HOLD);
                    if (cur_kind == 1) check_eq("R5 data value on line", sda_pull ? 0 : 1, cur_bit);
                    t_rise = cyc;
                end
            end else if (sda_pull !== prev_sda) begin
                if (scl_pull) begin
                    if (low_relax) check_ge("R10 data hold after ignored code", cyc - t_fall, HOLD);
                    else check_eq("R4 data hold", cyc - t_fall, HOLD);
                    sda_moved = 1;
                    t_sda_low = cyc;
                end else if (sda_pull) begin
                    if (cur_kind != 0) check_eq("R5 SDA fell while SCL high", 1, 0);
                    if (have_stop) begin
                        last_free = cyc - t_stop_rise;
                        if (free_relax) check_ge("R8 bus free", last_free, stop_half - 1);
                        else check_eq("R8 bus free", last_free, stop_half - 1);
                        have_stop = 0;
                        free_relax = 0;
                    end
                    if (rs_pending) check_eq("R7 repeated start setup", cyc - t_rise, cur_per);
                    t_sda_hi_fall = cyc;
                end else begin
                    if (cur_kind != 2) check_eq("R5 SDA rose while SCL high", 1, 0);
                    else check_eq("R6 stop setup", cyc - t_rise, cur_half + 2);
                    t_stop_rise = cyc;
                    have_stop = 1;
                    stop_half = cur_half;
                end
            end
            if (done && prev_done) check_eq("R9 pulse longer than one cycle", 1, 0);
            if (done) begin
                n_done++;
                if (cur_kind == 2) begin
                    check_eq("R6 done after stop", cyc - t_stop_rise, cur_half - 2);
                    check_eq("R6 lines released at done", int'(scl_pull) + int'(sda_pull), 0);
                end
            end
        end
        prev_scl  = scl_pull;
        prev_sda  = sda_pull;
        prev_done = done;
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    always @(posedge clk) begin
        if (cyc > 190000) begin
            errors++;
            $display("FAIL watchdog (R9 completion never seen): actual %0d cycles expected fewer", cyc);
            summary();
            $finish;
        end
    end

    // Called at negedge+1; returns at negedge+1 of the completion cycle.
    task automatic send(int op, int b, int per, bit noisy);
        cmd_valid = 1'b1;
        cmd_op    = op[1:0];
        cmd_bit   = b[0];
        period    = per[PW-1:0];
        if (op == 0) rs_pending = owned;
        cur_kind = op;
        cur_bit  = b;
        cur_half = per / 2;
        cur_per  = per;
        n_sent++;
        @(posedge clk);
        @(negedge clk); #1;
        cmd_valid = 1'b0;
        if (noisy) begin
            for (int i = 0; i < 3; i++) begin
                cmd_valid = 1'b1;
                cmd_op    = 2'($urandom % 4);
                cmd_bit   = 1'($urandom % 2);
                period    = PW'(16 + 2 * ($urandom % 40));
                @(negedge clk); #1;
            end
            cmd_valid = 1'b0;
            period    = per[PW-1:0];
        end
        while (!done) begin
            @(negedge clk); #1;
        end
        if (op == 0) owned = 1;
        if (op == 2) owned = 0;
    endtask

    task automatic run_txn(int per, int nbits, bit rs, int nbits2);
        send(0, 0, per, 0);
        for (int i = 0; i < nbits; i++) send(1, $urandom % 2, per, ($urandom % 4) == 0);
        if (rs) begin
            send(0, 0, per, ($urandom % 2) == 0);
            for (int i = 0; i < nbits2; i++) send(1, $urandom % 2, per, 0);
        end
        send(2, 0, per, 0);
    endtask

    initial begin
        void'($urandom(32'h1DC0_5EED));
        repeat (3) @(negedge clk);
        check_eq("R1 SCL released in reset", int'(scl_pull), 0);
        check_eq("R1 SDA released in reset", int'(sda_pull), 0);
        check_eq("R1 done low in reset", int'(done), 0);
        @(negedge clk); #1;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_eq("R1 SCL released after reset", int'(scl_pull), 0);
        check_eq("R1 SDA released after reset", int'(sda_pull), 0);
        check_eq("R1 done low after reset", int'(done), 0);
        mon_on = 1;
        #1;

        // Shortest period with a repeated start and bus noise.
        run_txn(16, 3, 1, 2);

        // R10: write, stop and none codes while the bus is free.
        for (int i = 0; i < 12; i++) begin
            cmd_valid = 1'b1;
            cmd_op    = 2'(1 + (i % 3));
            cmd_bit   = 1'(i % 2);
            @(negedge clk); #1;
            check_eq("R10 idle SCL untouched", int'(scl_pull), 0);
            check_eq("R10 idle SDA untouched", int'(sda_pull), 0);
            check_eq("R10 idle no done", int'(done), 0);
        end
        cmd_valid = 1'b0;
        free_relax = 1;

        // R10: reserved code while the bus is held.
        send(0, 0, 20, 0);
        send(1, 1, 20, 0);
        begin
            logic s0, d0;
            s0 = scl_pull;
            d0 = sda_pull;
            low_relax = 1;
            for (int i = 0; i < 6; i++) begin
                cmd_valid = 1'b1;
                cmd_op    = 2'b11;
                cmd_bit   = 1'(i % 2);
                @(negedge clk); #1;
                check_eq("R10 held SCL unchanged", int'(scl_pull), int'(s0));
                check_eq("R10 held SDA unchanged", int'(sda_pull), int'(d0));
                check_eq("R10 held no done", int'(done), 0);
            end
            cmd_valid = 1'b0;
        end
        send(1, 0, 20, 0);
        send(2, 0, 20, 0);

        // R11: standard class period.
        run_txn(500, 2, 1, 1);
        check_ge("R11 standard high ns", last_high * CLK_NS, 4000);
        check_ge("R11 standard low ns", last_low * CLK_NS, 4700);

        // R11: fast class period; the bus-free gap here follows the standard stop.
        run_txn(132, 3, 0, 0);
        check_ge("R11 standard bus free ns", last_free * CLK_NS, 4700);
        check_ge("R11 fast high ns", last_high * CLK_NS, 600);
        check_ge("R11 fast low ns", last_low * CLK_NS, 1300);

        // Random traffic.
        for (int t = 0; t < 16; t++) begin
            run_txn(16 + 2 * ($urandom % 32), 1 + $urandom % 8, ($urandom % 2) == 1, 1 + $urandom % 3);
        end

        repeat (4) @(negedge clk);
        check_eq("R9 one pulse per accepted command", n_done, n_sent);
        summary();
        $finish;
    end

endmodule